// File: doc/BRIEF.md
# DMA Channel Trigger Source Selector

This block sits in front of one channel of a multi-channel DMA engine and turns the channel's trigger configuration into a single request towards that channel. Configuration arrives as a 5-bit primary code, a 4-bit extended code, a demand-mode flag and a software trigger bit. The hardware candidates are a bank of external interrupt lines, a bank of reload-timer lines and the channel's own external request pin. The block decodes which source is selected, watches it for a rising edge or follows its level depending on the mode, and suppresses selections that are reserved, unpopulated or not permitted in the current mode.

A primary code with its top bit set picks a peripheral line by a request number built from the extended code and the low nibble of the primary code. Two dedicated primary codes pick the external request pin. That pin only exists on the lower-numbered channels, which is set by comparing the channel index parameter against a channel-count parameter. The request leaves as a valid/ready pair. An edge-detected request is held until the channel accepts it. In demand mode the request is a level that tracks the pin and ignores `req_ready`.

Top module: `dma_trig_select`

## Requirements
- R1: When `src_code[4]` is 1, the request number is `ext_code*16 + src_code[3:0]`. Numbers 16..23 select `ext_irq[0..7]` and numbers 32..37 select `tmr_irq[0..5]`, limited to the lines that exist.
- R2: Request numbers 24..31, numbers that map to missing peripheral lines, and all other numbers never produce a request.
- R3: Outside demand mode, a rising edge of the selected source raises `req_valid` on the next clock. `req_valid` then stays high until a clock edge at which `req_ready` is 1, and it is low on the following cycle unless a new edge arrives.
- R4: A rising edge of `sw_trig` raises `req_valid` on the next clock, whatever the codes and the mode are. The request is held and released as in R3.
- R5: Primary codes 01110 and 01111 select `ext_req`. This only works when `CHAN_IDX < EXT_REQ_CHANS`; on any other channel these codes never produce a request.
- R6: In demand mode with a legal code, `req_valid` equals `ext_req` delayed by one clock, in both the rising and the falling direction. `req_ready` has no effect on it.
- R7: In demand mode, any primary code other than 01110 or 01111 produces no hardware request and sets `cfg_err` at the next clock. `cfg_err` then stays 1 until reset.
- R8: When `rst_n` is low, the pending request, the level request and `cfg_err` are all cleared at once.
- R9: Primary codes 00000..01101 select no hardware source.
- R10: A source held high outside demand mode gives exactly one request per rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_code | input | 5 | Primary trigger source code |
| ext_code | input | 4 | Extended source code (upper part of the request number) |
| demand_mode | input | 1 | 1 selects demand transfer (level detection) |
| sw_trig | input | 1 | Software trigger; its rising edge requests a transfer |
| ext_irq | input | N_EXTINT | External interrupt lines |
| tmr_irq | input | N_TIMER | Reload timer lines |
| ext_req | input | 1 | The channel's external request pin |
| req_ready | input | 1 | The channel accepts a pending edge request |
| req_valid | output | 1 | Transfer request to the channel |
| cfg_err | output | 1 | Sticky flag: illegal code used in demand mode |

## Verification
The assertions assume that every input is synchronous to `clk`. They also assume that the code and mode fields do not change in the same cycle that the selected source rises, because a change of selection may itself look like an edge. The stimulus changes codes and mode only while all request sources are low, or while the new selection resolves to a source that stays quiet. Every input is driven on the falling clock edge. A second instance, configured as a channel without the external pin, runs alongside the first and must stay silent.

// File: rtl/dts_pkg.sv
package dts_pkg;
  localparam int SRC_W   = 5;
  localparam int XCODE_W = 4;
  localparam int RNUM_W  = XCODE_W + 4;
  localparam int EXTINT_BASE  = 16;
  localparam int EXTINT_SLOTS = 8;
  localparam int TIMER_BASE   = 32;
  localparam int TIMER_SLOTS  = 16;
  localparam logic [3:0] PIN_CODE_HI = 4'b0111;

  function automatic logic is_pin_code(input logic [SRC_W-1:0] code);
    return code[SRC_W-1:1] == PIN_CODE_HI;
  endfunction
endpackage

// File: rtl/dts_decode.sv
module dts_decode
  import dts_pkg::*;
#(
  parameter int N_EXTINT = 8,
  parameter int N_TIMER  = 6,
  parameter bit PIN_OK   = 1'b1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [SRC_W-1:0]    src_code,
  input  logic [XCODE_W-1:0]  ext_code,
  input  logic [N_EXTINT-1:0] ext_irq,
  input  logic [N_TIMER-1:0]  tmr_irq,
  input  logic                ext_req,
  output logic                sel_raw
);
  localparam int EI_USE = (N_EXTINT > EXTINT_SLOTS) ? EXTINT_SLOTS : N_EXTINT;
  localparam int TM_USE = (N_TIMER > TIMER_SLOTS) ? TIMER_SLOTS : N_TIMER;

  logic [RNUM_W-1:0] rnum;
  logic [EI_USE-1:0] ei_hit;
  logic [TM_USE-1:0] tm_hit;

  assign rnum = {ext_code, src_code[3:0]};

  for (genvar i = 0; i < EI_USE; i++) begin : g_ei
    assign ei_hit[i] = (rnum == RNUM_W'(EXTINT_BASE + i)) && ext_irq[i];
  end
  for (genvar j = 0; j < TM_USE; j++) begin : g_tm
    assign tm_hit[j] = (rnum == RNUM_W'(TIMER_BASE + j)) && tmr_irq[j];
  end

  always_comb begin
    if (src_code[SRC_W-1])
      sel_raw = |ei_hit || |tm_hit;
    else if (is_pin_code(src_code))
      sel_raw = PIN_OK && ext_req;
    else
      sel_raw = 1'b0;
  end

  // R2: reserved request numbers stay silent
  p_reserved_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (src_code[SRC_W-1] && rnum >= RNUM_W'(24) && rnum <= RNUM_W'(31)) |-> !sel_raw);
  // R9: plain primary codes select nothing
  p_plain_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!src_code[SRC_W-1] && !is_pin_code(src_code)) |-> !sel_raw);
  // R5: pin codes on a channel without the pin stay silent
  p_pin_absent_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!PIN_OK && is_pin_code(src_code)) |-> !sel_raw);
endmodule

// File: rtl/dts_edge.sv
module dts_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic sel_raw,
  input  logic edge_en,
  input  logic sw_trig,
  input  logic ack,
  output logic pend
);
  logic sel_q, sw_q, hit;

  assign hit = (edge_en && sel_raw && !sel_q) || (sw_trig && !sw_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= 1'b0;
      sw_q  <= 1'b0;
      pend  <= 1'b0;
    end else begin
      sel_q <= sel_raw;
      sw_q  <= sw_trig;
      pend  <= hit || (pend && !ack);
    end
  end

  // R3: an unaccepted request is held
  p_pend_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && !ack) |=> pend);
  // R4: software edge always raises a request
  p_sw_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_trig && !sw_q) |=> pend);
  // R10: no new request while the source stays high and nothing else fires
  p_one_per_edge_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && ack && sel_q && sel_raw && !(sw_trig && !sw_q)) |=> !pend);
endmodule

// File: rtl/dts_level.sv
module dts_level
  import dts_pkg::*;
#(
  parameter bit PIN_OK = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             demand_mode,
  input  logic [SRC_W-1:0] src_code,
  input  logic             ext_req,
  output logic             lvl_q,
  output logic             cfg_err
);
  logic legal;
  assign legal = is_pin_code(src_code);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q   <= 1'b0;
      cfg_err <= 1'b0;
    end else begin
      lvl_q   <= demand_mode && legal && PIN_OK && ext_req;
      cfg_err <= cfg_err || (demand_mode && !legal);
    end
  end

  // R6: level request follows the pin one cycle late
  p_level_tracks_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (demand_mode && legal) |=> (lvl_q == (PIN_OK && $past(ext_req))));
  // R6: no level request outside demand mode
  p_level_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !demand_mode |=> !lvl_q);
  // R7: illegal demand code flags an error
  p_illegal_flags_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (demand_mode && !legal) |=> cfg_err);
  // R7: error flag is sticky
  p_err_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |=> cfg_err);
endmodule

// File: rtl/dma_trig_select.sv
module dma_trig_select
  import dts_pkg::*;
#(
  parameter int CHAN_IDX      = 0,
  parameter int EXT_REQ_CHANS = 3,
  parameter int N_EXTINT      = 8,
  parameter int N_TIMER       = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [4:0]          src_code,
  input  logic [3:0]          ext_code,
  input  logic                demand_mode,
  input  logic                sw_trig,
  input  logic [N_EXTINT-1:0] ext_irq,
  input  logic [N_TIMER-1:0]  tmr_irq,
  input  logic                ext_req,
  input  logic                req_ready,
  output logic                req_valid,
  output logic                cfg_err
);
  localparam bit PIN_OK = (CHAN_IDX < EXT_REQ_CHANS);

  logic sel_raw, pend, lvl_q;

  dts_decode #(.N_EXTINT(N_EXTINT), .N_TIMER(N_TIMER), .PIN_OK(PIN_OK)) u_decode (
    .clk(clk), .rst_n(rst_n), .src_code(src_code), .ext_code(ext_code),
    .ext_irq(ext_irq), .tmr_irq(tmr_irq), .ext_req(ext_req), .sel_raw(sel_raw)
  );

  dts_edge u_edge (
    .clk(clk), .rst_n(rst_n), .sel_raw(sel_raw), .edge_en(!demand_mode),
    .sw_trig(sw_trig), .ack(req_ready), .pend(pend)
  );

  dts_level #(.PIN_OK(PIN_OK)) u_level (
    .clk(clk), .rst_n(rst_n), .demand_mode(demand_mode), .src_code(src_code),
    .ext_req(ext_req), .lvl_q(lvl_q), .cfg_err(cfg_err)
  );

  assign req_valid = pend || lvl_q;

  // R3: a rising selected source outside demand mode yields a request next cycle
  p_edge_request_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!demand_mode && $rose(sel_raw)) |=> req_valid);
endmodule

// File: tb/dma_trig_select_bench.sv
module dma_trig_select_bench;
  typedef struct {
    logic  v;
    logic  e;
    string tag;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] src_code = '0;
  logic [3:0] ext_code = '0;
  logic       demand_mode = 1'b0;
  logic       sw_trig = 1'b0;
  logic [7:0] ext_irq = '0;
  logic [5:0] tmr_irq = '0;
  logic       ext_req = 1'b0;
  logic       req_ready = 1'b0;
  logic       req_valid, cfg_err;
  logic       hi_valid, hi_err;

  int   checks = 0;
  int   errors = 0;
  bit   done = 1'b0;
  exp_t q[$];

  always #4 clk = ~clk;

  dma_trig_select u_dma_trig_select (
    .clk(clk), .rst_n(rst_n), .src_code(src_code), .ext_code(ext_code),
    .demand_mode(demand_mode), .sw_trig(sw_trig), .ext_irq(ext_irq),
    .tmr_irq(tmr_irq), .ext_req(ext_req), .req_ready(req_ready),
    .req_valid(req_valid), .cfg_err(cfg_err)
  );

  // channel without the external pin, demand mode, pin code selected
  dma_trig_select #(.CHAN_IDX(3)) u_dma_trig_select_hi (
    .clk(clk), .rst_n(rst_n), .src_code(5'b01110), .ext_code(4'b0000),
    .demand_mode(1'b1), .sw_trig(1'b0), .ext_irq(ext_irq),
    .tmr_irq(tmr_irq), .ext_req(ext_req), .req_ready(1'b1),
    .req_valid(hi_valid), .cfg_err(hi_err)
  );

  task automatic check(input bit ok, input string tag, input logic [1:0] act,
                       input logic [1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cyc(input logic v, input logic e, input string tag);
    exp_t it;
    it.v = v; it.e = e; it.tag = tag;
    q.push_back(it);
    @(posedge clk);
    @(negedge clk);
  endtask

  // monitor: pops one expectation per clock, samples 2 ns after the edge
  always @(posedge clk) begin
    #2;
    if (q.size() > 0) begin
      exp_t it;
      it = q.pop_front();
      check({req_valid, cfg_err} === {it.v, it.e}, it.tag,
            {req_valid, cfg_err}, {it.v, it.e});
      check({hi_valid, hi_err} === 2'b00, "R5 pinless channel",
            {hi_valid, hi_err}, 2'b00);
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R3 watchdog expired actual=hung expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    check({req_valid, cfg_err} === 2'b00, "R8 reset state", {req_valid, cfg_err}, 2'b00);
    rst_n = 1'b1;

    // R1: external interrupt 0 via number 16
    src_code = 5'b10000; ext_code = 4'b0001;
    cyc(0, 0, "R1 idle");
    ext_irq[0] = 1'b1;     cyc(1, 0, "R1 extint0 edge");
    cyc(1, 0, "R3 held without ready");
    req_ready = 1'b1;      cyc(0, 0, "R3 released by ready");
    req_ready = 1'b0;      cyc(0, 0, "R10 level held no repeat");
    ext_irq[0] = 1'b0;     cyc(0, 0, "R1 low");

    // R1: reload timer 5 via number 37
    src_code = 5'b10101; ext_code = 4'b0010;
    cyc(0, 0, "R1 idle timer");
    tmr_irq[4] = 1'b1;     cyc(0, 0, "R1 wrong timer");
    tmr_irq[4] = 1'b0; tmr_irq[5] = 1'b1; cyc(1, 0, "R1 timer5 edge");
    req_ready = 1'b1;      cyc(0, 0, "R3 accept");
    req_ready = 1'b0; tmr_irq[5] = 1'b0; cyc(0, 0, "R1 low");

    // R2: reserved and unpopulated numbers
    src_code = 5'b11000; ext_code = 4'b0001;
    ext_irq = 8'hFF; tmr_irq = 6'h3F;  cyc(0, 0, "R2 number 24");
    src_code = 5'b10110; ext_code = 4'b0010; cyc(0, 0, "R2 number 38");
    src_code = 5'b10000; ext_code = 4'b0011; cyc(0, 0, "R2 number 48");
    src_code = 5'b11111; ext_code = 4'b0000; cyc(0, 0, "R2 number 15");
    ext_irq = '0; tmr_irq = '0;        cyc(0, 0, "R2 low");

    // R4: software trigger with a reserved selection
    src_code = 5'b11000; ext_code = 4'b0001;
    sw_trig = 1'b1;        cyc(1, 0, "R4 software edge");
    req_ready = 1'b1;      cyc(0, 0, "R4 accept, no repeat");
    req_ready = 1'b0; sw_trig = 1'b0; cyc(0, 0, "R4 low");

    // R5: external pin, edge mode, both codes
    src_code = 5'b01110;   cyc(0, 0, "R5 idle");
    ext_req = 1'b1;        cyc(1, 0, "R5 pin edge code 01110");
    req_ready = 1'b1;      cyc(0, 0, "R5 accept");
    req_ready = 1'b0; ext_req = 1'b0; cyc(0, 0, "R5 low");
    src_code = 5'b01111;   cyc(0, 0, "R5 idle 01111");
    ext_req = 1'b1;        cyc(1, 0, "R5 pin edge code 01111");
    req_ready = 1'b1;      cyc(0, 0, "R5 accept");
    req_ready = 1'b0; ext_req = 1'b0; cyc(0, 0, "R5 low");

    // R9: plain code selects nothing
    src_code = 5'b00101;   cyc(0, 0, "R9 idle");
    ext_req = 1'b1; ext_irq[0] = 1'b1; cyc(0, 0, "R9 plain code quiet");
    ext_req = 1'b0; ext_irq[0] = 1'b0; cyc(0, 0, "R9 low");

    // R6: demand mode level tracking
    src_code = 5'b01110; demand_mode = 1'b1; cyc(0, 0, "R6 idle");
    ext_req = 1'b1;        cyc(1, 0, "R6 level rises");
    req_ready = 1'b1;      cyc(1, 0, "R6 ready ignored");
    cyc(1, 0, "R6 still high");
    ext_req = 1'b0;        cyc(0, 0, "R6 level falls");
    req_ready = 1'b0;      cyc(0, 0, "R6 low");

    // R7: illegal code in demand mode
    src_code = 5'b10000; ext_code = 4'b0001; ext_irq[0] = 1'b1;
    cyc(0, 1, "R7 illegal demand code");
    cyc(0, 1, "R7 sticky");
    sw_trig = 1'b1;        cyc(1, 1, "R4 software in demand mode");
    req_ready = 1'b1;      cyc(0, 1, "R4 accept");
    req_ready = 1'b0; sw_trig = 1'b0; demand_mode = 1'b0; cyc(0, 1, "R7 sticky after mode change");
    ext_irq[0] = 1'b0;     cyc(0, 1, "R7 low");
    ext_irq[0] = 1'b1;     cyc(1, 1, "R3 edge before reset");

    // R8: reset clears pending and error
    rst_n = 1'b0; ext_irq[0] = 1'b0; cyc(0, 0, "R8 reset clears");
    rst_n = 1'b1;          cyc(0, 0, "R8 after reset");
    cyc(0, 0, "R8 stays clear");

    @(posedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule